// File: doc/BRIEF.md
# SPI Master Frame Sequencer

This block is the serial engine of a synchronous serial master. It takes words from a transmit queue through a valid/ready handshake and shifts them out on MOSI, most significant bit first. At the same time it shifts MISO in and hands each finished word to a receive queue. It produces SCK and an active-low slave select in all four combinations of clock polarity and clock phase. The word length can be set from 4 to 16 bits. The SCK rate comes from a prescale value, and one half-period lasts prescale+1 system clocks.

Slave select falls when a word is accepted. It stays low for as long as the transmit side keeps offering words at each word boundary, and it rises one full SCK period after the last sampling edge. Polarity, phase, word size and prescale are captured when slave select falls. They are held until the sequence is back at rest, so a frame is never disturbed by a change on these inputs.

A received word is kept in a single holding slot until the receive side takes it. If a newer word arrives while the slot is still occupied, the newer word replaces the old one and a sticky overrun flag is raised.

Top module: `spi_frame_master`

## Requirements
- R1: While at rest (no frame in progress), ssel_n is 1, mosi_oe is 0, and sck follows the cpol input one clock later.
- R2: A frame starts only when en is 1 and tx_valid is 1; tx_ready is then 1 and the word is taken. On the next clock ssel_n is 0 and mosi_oe is 1. With en at 0, tx_ready stays 0 and ssel_n stays 1.
- R3: One SCK half-period lasts prescale+1 clocks. The first SCK edge comes prescale+1 clocks after ssel_n falls.
- R4: With cpha=0, bit N-1 of the word is on mosi when ssel_n falls. Odd-numbered SCK edges (1st, 3rd, ...) are sampling edges, and mosi changes only on even-numbered edges.
- R5: With cpha=1, mosi changes only on odd-numbered SCK edges and miso is sampled on even-numbered edges.
- R6: Each word has N = clamp(word_bits, 4, 16) bits, sent most significant first, so a word takes exactly 2N SCK edges. A word_bits value below 4 acts as 4 and a value above 16 acts as 16. Bits of tx_data at position N and above are ignored.
- R7: ssel_n rises 2*(prescale+1) clocks after the last sampling edge of the final word.
- R8: If en and tx_valid are both 1 at the final SCK edge of a word, the next word is taken at that edge. ssel_n stays 0 and SCK carries on without a gap.
- R9: Each received word appears on rx_valid. rx_data holds the N sampled bits right-aligned: the first bit sampled goes to bit N-1, and the bits above are 0.
- R10: rx_valid and rx_data hold until rx_ready is 1. A new word that arrives while the slot is still held replaces rx_data and sets rx_overrun, which stays 1 until reset.
- R11: cpol, cpha, word_bits and prescale are captured when ssel_n falls. Later changes to them have no effect until the frame sequence is back at rest.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| en | input | 1 | Allows new words to be taken |
| cpol | input | 1 | SCK rest level |
| cpha | input | 1 | 0: sample on the leading edge; 1: sample on the trailing edge |
| word_bits | input | 5 | Requested word length in bits |
| prescale | input | 8 | Half-period length minus one, in clocks |
| tx_valid | input | 1 | Transmit word offered |
| tx_data | input | 16 | Transmit word, right-aligned |
| tx_ready | output | 1 | Word taken on this clock when tx_valid is 1 |
| rx_valid | output | 1 | Holding slot occupied |
| rx_data | output | 16 | Received word, right-aligned |
| rx_ready | input | 1 | Receive side takes the held word |
| rx_overrun | output | 1 | Sticky: a held word was replaced |
| sck | output | 1 | Serial clock |
| ssel_n | output | 1 | Slave select, active low |
| mosi | output | 1 | Serial data out |
| mosi_oe | output | 1 | Drive enable for mosi |
| miso | input | 1 | Serial data in |

## Verification
The hardest cases to reach from the ports are two edge-coincidence situations. In the first, the word boundary in a continuous burst falls on the same clock as the last sample and the load of the next word. In the second, configuration inputs change while a frame is running. The bench covers the first by offering the next word as soon as the previous one is taken, so tx_valid is already 1 at the final edge. This is done in both phase modes, because the boundary falls on a driving edge in one mode and on a sampling edge in the other. For the second, the bench changes polarity, phase, length and prescale halfway through a word and checks the edge count, the captured bits and the timing against the values captured at the start. A monitor on mosi flags any mosi change that falls on a sampling edge. miso is driven as the inverse of mosi, so both directions of the bit order are checked against the word that was sent.

// File: rtl/spi_fm_pkg.sv
package spi_fm_pkg;

  typedef enum logic {ST_IDLE, ST_RUN} seq_state_t;

  // word length actually used for a requested length
  function automatic int unsigned clamp_len(int unsigned req, int unsigned lo, int unsigned hi);
    if (req < lo) return lo;
    if (req > hi) return hi;
    return req;
  endfunction

  // half-period index at whose end slave select is released
  function automatic int unsigned final_half(int unsigned n, logic cpha);
    return 2 * n + (cpha ? 1 : 0);
  endfunction

  // half-period index whose closing edge samples the last bit
  function automatic int unsigned final_sample(int unsigned n, logic cpha);
    return 2 * n - 2 + (cpha ? 1 : 0);
  endfunction

  // the edge closing half-period hc samples when its parity matches cpha
  function automatic logic edge_samples(logic hc_lsb, logic cpha);
    return hc_lsb == cpha;
  endfunction

endpackage

// File: rtl/spi_half_tick.sv
module spi_half_tick #(
  parameter int unsigned CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clear,
  input  logic [CNT_W-1:0] limit,
  output logic             tick
);
  logic [CNT_W-1:0] cnt;

  assign tick = !clear && (cnt == limit);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              cnt <= '0;
    else if (clear || tick)  cnt <= '0;
    else                     cnt <= cnt + 1'b1;
  end

  // R3: the half-period counter never runs past its limit
  a_r3_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
    !clear |-> cnt <= limit);

endmodule

// File: rtl/spi_rx_hold.sv
module spi_rx_hold #(
  parameter int unsigned W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         push,
  input  logic [W-1:0] push_data,
  input  logic         rx_ready,
  output logic         rx_valid,
  output logic [W-1:0] rx_data,
  output logic         overrun
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rx_valid <= 1'b0;
      rx_data  <= '0;
      overrun  <= 1'b0;
    end else begin
      if (push) begin
        rx_data  <= push_data;
        rx_valid <= 1'b1;
        if (rx_valid && !rx_ready) overrun <= 1'b1;
      end else if (rx_valid && rx_ready) begin
        rx_valid <= 1'b0;
      end
    end
  end

  // R10: an untaken word is held unchanged
  a_r10_hold: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid && !rx_ready && !push |=> rx_valid && $stable(rx_data));

  // R10: overrun only rises when a held word is replaced
  a_r10_overrun_cause: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(overrun) |-> $past(push && rx_valid && !rx_ready));

endmodule

// File: rtl/spi_frame_master.sv
module spi_frame_master
  import spi_fm_pkg::*;
#(
  parameter int unsigned MAX_BITS = 16,
  parameter int unsigned MIN_BITS = 4,
  parameter int unsigned PRE_W    = 8,
  localparam int unsigned LEN_W   = $clog2(MAX_BITS + 1),
  localparam int unsigned HC_W    = $clog2(2 * MAX_BITS + 2)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                en,
  input  logic                cpol,
  input  logic                cpha,
  input  logic [LEN_W-1:0]    word_bits,
  input  logic [PRE_W-1:0]    prescale,
  input  logic                tx_valid,
  input  logic [MAX_BITS-1:0] tx_data,
  output logic                tx_ready,
  output logic                rx_valid,
  output logic [MAX_BITS-1:0] rx_data,
  input  logic                rx_ready,
  output logic                rx_overrun,
  output logic                sck,
  output logic                ssel_n,
  output logic                mosi,
  output logic                mosi_oe,
  input  logic                miso
);
  seq_state_t           state;
  logic                 cpol_l, cpha_l;
  logic [LEN_W-1:0]     n_l;
  logic [PRE_W-1:0]     pre_l;
  logic [HC_W-1:0]      hc;
  logic [MAX_BITS-1:0]  txsh;
  logic [MAX_BITS-2:0]  rxsh;
  logic                 mosi_q, sck_q;

  // named events for the sequencer and its checks
  logic                 running, tick, edge_ev, sample_ev, drive_ev;
  logic                 word_end, last_sample_ev, frame_done;
  logic                 start_ev, chain_ev, load_ev, cpha_eff;
  logic [LEN_W-1:0]     n_req, n_eff;
  logic [MAX_BITS-1:0]  just, rx_word;

  assign running   = (state == ST_RUN);
  assign n_req     = LEN_W'(clamp_len(32'(word_bits), MIN_BITS, MAX_BITS));

  spi_half_tick #(.CNT_W(PRE_W)) u_tick (
    .clk   (clk),
    .rst_n (rst_n),
    .clear (!running),
    .limit (pre_l),
    .tick  (tick)
  );

  assign edge_ev        = running && tick && (hc < HC_W'(2 * 32'(n_l)));
  assign sample_ev      = edge_ev && edge_samples(hc[0], cpha_l);
  assign drive_ev       = edge_ev && !edge_samples(hc[0], cpha_l);
  assign word_end       = running && tick && (hc == HC_W'(2 * 32'(n_l) - 1));
  assign last_sample_ev = sample_ev && (hc == HC_W'(final_sample(32'(n_l), cpha_l)));
  assign frame_done     = running && tick && (hc == HC_W'(final_half(32'(n_l), cpha_l)));

  assign start_ev = !running && en && tx_valid;
  assign chain_ev = word_end && en && tx_valid;
  assign load_ev  = start_ev || chain_ev;
  assign tx_ready = en && (!running || word_end);

  assign n_eff    = start_ev ? n_req : n_l;
  assign cpha_eff = start_ev ? cpha  : cpha_l;
  assign just     = tx_data << (MAX_BITS - 32'(n_eff));
  assign rx_word  = {rxsh, miso};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state  <= ST_IDLE;
      cpol_l <= 1'b0;
      cpha_l <= 1'b0;
      n_l    <= LEN_W'(MIN_BITS);
      pre_l  <= '0;
      hc     <= '0;
      txsh   <= '0;
      rxsh   <= '0;
      mosi_q <= 1'b0;
      sck_q  <= 1'b0;
    end else begin
      if (!running) sck_q <= cpol;
      if (sample_ev) rxsh <= rx_word[MAX_BITS-2:0];
      if (drive_ev) begin
        mosi_q <= txsh[MAX_BITS-1];
        txsh   <= txsh << 1;
      end
      if (edge_ev) sck_q <= ~sck_q;
      if (running && tick) hc <= hc + 1'b1;
      if (frame_done) state <= ST_IDLE;
      if (load_ev) begin
        state <= ST_RUN;
        hc    <= '0;
        rxsh  <= '0;
        txsh  <= cpha_eff ? just : (just << 1);
        // a chained trailing-phase load meets a sampling edge: keep mosi
        if (start_ev || !cpha_eff) mosi_q <= just[MAX_BITS-1];
        if (start_ev) begin
          cpol_l <= cpol;
          cpha_l <= cpha;
          n_l    <= n_req;
          pre_l  <= prescale;
          sck_q  <= cpol;
        end
      end
    end
  end

  assign sck     = sck_q;
  assign ssel_n  = !running;
  assign mosi    = mosi_q;
  assign mosi_oe = running;

  spi_rx_hold #(.W(MAX_BITS)) u_rx (
    .clk       (clk),
    .rst_n     (rst_n),
    .push      (last_sample_ev),
    .push_data (rx_word),
    .rx_ready  (rx_ready),
    .rx_valid  (rx_valid),
    .rx_data   (rx_data),
    .overrun   (rx_overrun)
  );

  // R1: at rest sck tracks the polarity input
  a_r1_idle_sck: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) && ssel_n && $past(ssel_n) |-> sck == $past(cpol));

  // R2: an accepted word from rest opens a frame
  a_r2_start: assert property (@(posedge clk) disable iff (!rst_n)
    ssel_n && tx_valid && tx_ready |=> !ssel_n && mosi_oe);

  // R4 R5: mosi never moves on a sampling edge
  a_r4_mosi_still_at_sample: assert property (@(posedge clk) disable iff (!rst_n)
    sample_ev |=> $stable(mosi));

  // R8: a word taken mid-frame keeps select low
  a_r8_no_gap: assert property (@(posedge clk) disable iff (!rst_n)
    !ssel_n && tx_valid && tx_ready |=> !ssel_n);

  // R11: captured settings hold while a frame runs
  a_r11_cfg_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    running && $past(running) && !$past(start_ev) |->
      $stable(cpol_l) && $stable(cpha_l) && $stable(n_l) && $stable(pre_l));

endmodule

// File: tb/spi_frame_master_tb_top.sv
`timescale 1ns/1ps
module spi_frame_master_tb_top;
  logic        clk = 1'b0, rst_n = 1'b0;
  logic        en = 1'b1, cpol = 1'b0, cpha = 1'b0;
  logic [4:0]  word_bits = 5'd8;
  logic [7:0]  prescale = 8'd0;
  logic        tx_valid = 1'b0;
  logic [15:0] tx_data = '0;
  logic        tx_ready, rx_valid, rx_overrun, sck, ssel_n, mosi, mosi_oe, miso;
  logic [15:0] rx_data;
  logic        rx_ready = 1'b1;

  always #2.5 clk = ~clk;
  assign miso = ~mosi;

  spi_frame_master dut_i (
    .clk(clk), .rst_n(rst_n), .en(en), .cpol(cpol), .cpha(cpha),
    .word_bits(word_bits), .prescale(prescale), .tx_valid(tx_valid),
    .tx_data(tx_data), .tx_ready(tx_ready), .rx_valid(rx_valid),
    .rx_data(rx_data), .rx_ready(rx_ready), .rx_overrun(rx_overrun),
    .sck(sck), .ssel_n(ssel_n), .mosi(mosi), .mosi_oe(mosi_oe), .miso(miso)
  );

  int checks = 0, fails = 0;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // ---------------- line monitor ----------------
  logic        m_cpol = 1'b0, m_cpha = 1'b0;
  int          m_n = 8;
  int          cyc = 0, t_fall = 0, t_first = 0, t_last = 0, t_rise = 0;
  int          edges = 0, nsamp = 0, ncap = 0, nrx = 0, rises = 0, falls = 0, glitches = 0;
  logic        first_seen = 1'b0, mosi_at_fall = 1'b0, oe_at_fall = 1'b0;
  logic [15:0] capw = '0;
  logic [15:0] caps [8];
  logic [15:0] rxs  [8];
  logic        p_sck = 1'b0, p_ssel = 1'b1, p_mosi = 1'b0;

  always @(negedge clk) begin
    logic samp;
    samp = 1'b0;
    cyc++;
    if (p_ssel && !ssel_n) begin
      t_fall = cyc; falls++; first_seen = 1'b0;
      mosi_at_fall = mosi; oe_at_fall = mosi_oe;
    end
    if (!p_ssel && ssel_n) begin t_rise = cyc; rises++; end
    if (sck != p_sck) begin
      edges++;
      if (!first_seen) begin t_first = cyc; first_seen = 1'b1; end
      samp = (sck != m_cpol) ^ m_cpha;
      if (samp) begin
        capw = {capw[14:0], mosi};
        nsamp++;
        t_last = cyc;
        if (nsamp == m_n) begin
          if (ncap < 8) caps[ncap] = capw;
          ncap++; nsamp = 0; capw = '0;
        end
      end
    end
    if (!ssel_n && !p_ssel && (mosi != p_mosi) && !((sck != p_sck) && !samp))
      glitches++;
    if (rx_valid && rx_ready) begin
      if (nrx < 8) rxs[nrx] = rx_data;
      nrx++;
    end
    p_sck = sck; p_ssel = ssel_n; p_mosi = mosi;
  end

  task automatic mon_clear();
    edges = 0; nsamp = 0; ncap = 0; nrx = 0; rises = 0; falls = 0;
    glitches = 0; capw = '0; first_seen = 1'b0;
  endtask

  task automatic send(input logic [15:0] d);
    logic got;
    got = 1'b0;
    tx_data = d; tx_valid = 1'b1;
    while (!got) begin
      @(negedge clk);
      got = tx_ready;
    end
    @(posedge clk); #1;
    tx_valid = 1'b0;
  endtask

  task automatic setup(input logic c, input logic h, input logic [4:0] rq, input int n, input logic [7:0] p);
    @(posedge clk); #1;
    cpol = c; cpha = h; word_bits = rq; prescale = p;
    repeat (3) @(posedge clk);
    #1;
    mon_clear();
    m_cpol = c; m_cpha = h; m_n = n;
  endtask

  function automatic logic [15:0] mask_of(input int n);
    return 16'((32'd1 << n) - 1);
  endfunction

  task automatic run_single(input logic c, input logic h, input logic [4:0] rq, input int n,
                            input logic [7:0] p, input logic [15:0] d);
    logic [15:0] m;
    m = mask_of(n);
    setup(c, h, rq, n, p);
    send(d);
    wait (rises == 1);
    #1;
    chk("R2 drive enabled at select fall", 32'(oe_at_fall), 32'd1);
    chk("R6 bits seen on mosi msb first", 32'(caps[0]), 32'(d & m));
    chk("R6 word count", 32'(ncap), 32'd1);
    chk("R6 edge count 2N", 32'(edges), 32'(2 * n));
    chk("R9 received word", 32'(rxs[0]), 32'(~d & m));
    chk("R3 first edge delay", 32'(t_first - t_fall), 32'(p) + 1);
    chk("R7 select release delay", 32'(t_rise - t_last), 2 * (32'(p) + 1));
    if (h) chk("R5 mosi moves only on drive edges", 32'(glitches), 32'd0);
    else begin
      chk("R4 mosi moves only on drive edges", 32'(glitches), 32'd0);
      chk("R4 msb present at select fall", 32'(mosi_at_fall), 32'(d[n-1]));
    end
    repeat (2) @(posedge clk);
    #1;
    chk("R1 rest sck level", 32'(sck), 32'(c));
    chk("R1 rest drive off", 32'(mosi_oe), 32'd0);
  endtask

  logic [15:0] bw [3];

  task automatic run_burst(input logic c, input logic h, input int n, input logic [7:0] p, input int cnt);
    logic [15:0] m;
    m = mask_of(n);
    setup(c, h, 5'(n), n, p);
    for (int i = 0; i < cnt; i++) send(bw[i]);
    wait (rises == 1);
    #1;
    chk("R8 single select low period", 32'(falls), 32'd1);
    chk("R8 words in burst", 32'(ncap), 32'(cnt));
    chk("R8 edges in burst", 32'(edges), 32'(2 * n * cnt));
    chk("R8 no mosi change on sampling edges", 32'(glitches), 32'd0);
    chk("R7 burst release delay", 32'(t_rise - t_last), 2 * (32'(p) + 1));
    for (int i = 0; i < cnt; i++) begin
      chk("R8 burst word sent", 32'(caps[i]), 32'(bw[i] & m));
      chk("R9 burst word received", 32'(rxs[i]), 32'(~bw[i] & m));
    end
  endtask

  // {cpol, cpha, spare, nbits[4:0]}, prescale, data
  localparam logic [31:0] VEC [8] = '{
    32'h0801_00A5, 32'h4800_003C, 32'h9002_BEEF, 32'hC403_FFF9,
    32'h0C00_09C3, 32'hCD01_1ABC, 32'h5004_8001, 32'h8500_0015
  };

  task automatic finish_up();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog expired actual=running expected=done");
    finish_up();
  end

  initial begin
    repeat (4) @(posedge clk);
    #1;
    chk("R1 reset select high", 32'(ssel_n), 32'd1);
    chk("R1 reset drive off", 32'(mosi_oe), 32'd0);
    rst_n = 1'b1;
    repeat (2) @(posedge clk);
    #1;
    chk("R1 rest sck low", 32'(sck), 32'd0);
    chk("R10 no word after reset", 32'(rx_valid), 32'd0);
    chk("R10 no overrun after reset", 32'(rx_overrun), 32'd0);

    // R2: disabled block ignores an offered word
    mon_clear();
    en = 1'b0; tx_data = 16'h0055; tx_valid = 1'b1;
    repeat (40) @(posedge clk);
    #1;
    chk("R2 no ready while disabled", 32'(tx_ready), 32'd0);
    chk("R2 no frame while disabled", 32'(falls), 32'd0);
    tx_valid = 1'b0; en = 1'b1;

    for (int i = 0; i < 8; i++) begin
      logic [31:0] v;
      v = VEC[i];
      run_single(v[31], v[30], v[28:24], int'(v[28:24]), v[23:16], v[15:0]);
    end

    // R6 clamping of the length request
    run_single(1'b0, 1'b1, 5'd2, 4, 8'd1, 16'h000B);
    run_single(1'b0, 1'b0, 5'd20, 16, 8'd0, 16'h8421);

    // R8 back-to-back words in both phase modes
    bw[0] = 16'h005A; bw[1] = 16'h00C3; bw[2] = 16'h000F;
    run_burst(1'b0, 1'b1, 8, 8'd1, 3);
    bw[0] = 16'h0009; bw[1] = 16'h0006; bw[2] = 16'h000E;
    run_burst(1'b1, 1'b0, 4, 8'd0, 3);

    // R11: settings changed mid-frame are ignored
    setup(1'b0, 1'b0, 5'd8, 8, 8'd2);
    fork
      send(16'h0096);
      begin
        wait (falls == 1);
        repeat (10) @(posedge clk);
        #1;
        cpol = 1'b1; cpha = 1'b1; word_bits = 5'd4; prescale = 8'd0;
      end
    join
    wait (rises == 1);
    #1;
    chk("R11 edge count kept", 32'(edges), 32'd16);
    chk("R11 word kept", 32'(caps[0]), 32'h96);
    chk("R11 first edge delay kept", 32'(t_first - t_fall), 32'd3);
    chk("R11 release delay kept", 32'(t_rise - t_last), 32'd6);
    repeat (3) @(posedge clk);
    #1;
    chk("R11 new polarity after rest", 32'(sck), 32'd1);

    // R10: holding slot and overrun
    rx_ready = 1'b0;
    setup(1'b0, 1'b0, 5'd8, 8, 8'd0);
    send(16'h0011);
    wait (rises == 1);
    #1;
    chk("R10 word held", 32'(rx_valid), 32'd1);
    chk("R10 held data", 32'(rx_data), 32'h00EE);
    chk("R10 no overrun yet", 32'(rx_overrun), 32'd0);
    mon_clear();
    send(16'h0022);
    wait (rises == 1);
    #1;
    chk("R10 newer word replaces", 32'(rx_data), 32'h00DD);
    chk("R10 overrun raised", 32'(rx_overrun), 32'd1);
    @(negedge clk);
    rx_ready = 1'b1;
    @(posedge clk); #1;
    chk("R10 slot freed on ready", 32'(rx_valid), 32'd0);
    repeat (3) @(posedge clk);
    #1;
    chk("R10 overrun sticky", 32'(rx_overrun), 32'd1);

    finish_up();
  end
endmodule